// File: doc/BRIEF.md
# Three-Channel Reloadable Timer Unit

The block holds three down-counting timer channels behind one byte-addressed register bus. Each bus access takes one cycle. Each channel counts down on ticks from a shared free-running prescaler, and it does so only while its run bit is set. When a channel counts past zero it loads its reload constant again and raises an underflow flag. If the channel's interrupt enable is set, that flag drives the channel's own interrupt output.

Two registers sit in front of the channel windows and are shared by all channels:
- **Output-control register** (optional). It keeps one bit and drives an output pin.
- **Run register.** It holds one start/stop bit per channel.

A parameter removes channel 2. The capture register lives only in channel 2, so it goes too, and the addresses those registers used become undecoded. Reading an undecoded offset returns zero and raises a sticky bus-error flag.

Top module: `tmr_unit`

## Requirements
- R1: While `rst` is high and after it falls, every reload constant and counter holds all ones, every control register holds 0, the run register holds 0, the output-control bit is 0, the capture register holds `CAPT_INIT`, and `bus_rdata`, `bus_err` and every `irq` bit are 0.
- R2: Byte offsets decode as follows. 0x00 is output control and 0x04 is the run register. Channel n owns a window at 0x08 + 12·n, with the reload constant at +0, the counter at +4 and the control register at +8. Only channel 2 also has the capture register, at 0x2C. Every register reads back what was last written to it, unless counting has changed it.
- R3: Run register bits 0, 1 and 2 let channels 0, 1 and 2 count. Only those three bits are stored, and bits above them read as 0. A new run value first acts on the clock edge after the write edge.
- R4: On each edge where its run bit is set and its selected tick is present, a channel's counter goes down by one. On such an edge with the counter at 0, the counter loads the reload constant and the channel's underflow flag is set.
- R5: Control bits [2:0] hold a prescale select k. The shared prescaler is cleared by reset and counts every clock. When k is 0 to 3, the selected tick occurs on edges where (prescaler mod 4^(k+1)) equals 4^(k+1)−1. Every k of 4 or above uses division by 1024.
- R6: Clearing a run bit freezes that counter. Setting the bit again resumes counting from the frozen value, with no reload.
- R7: Control bit 3 enables the interrupt and control bit 4 is the underflow flag. A channel's `irq` bit equals flag AND enable as they stood one cycle earlier. Writing the control register with bit 4 clear clears the flag, and writing it with bit 4 set leaves the flag unchanged. An underflow on the same edge as such a write sets the flag.
- R8: A write to a channel's counter takes effect in place of any count step or reload on that edge.
- R9: The output-control register keeps only bit 0 and drives `out_ctl`. When `HAS_OUTCTL` is 0, offset 0x00 is undecoded and `out_ctl` stays 0.
- R10: A read of an undecoded or misaligned offset returns 0 and sets `bus_err`, which stays set until reset. A write to such an offset changes nothing.
- R11: When `HAS_CH2` is 0, offsets from 0x20 upward are undecoded. Writing the run register with bit 2 set then sets `bus_err`, and bit 2 stays 0.
- R12: `bus_rdata` takes the read value on the edge that ends a read cycle. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Sticky bus-error flag |
| irq | output | NCH | One interrupt per channel |
| out_ctl | output | 1 | Output-control bit |

## Verification
The bench builds two instances:
- **Default build, with channel 2 and the output-control register present.** A cycle model checks this instance on every clock. The model covers counting with several prescale selects, clamping of select 7, reload on wrap, flag clear and keep, freeze and resume, counter writes while the channel runs, and the capture register.
- **Second build, with `HAS_CH2` and `HAS_OUTCTL` both 0.** This instance reaches cases the default build cannot: the rejected run bit 2, the undecoded window from 0x20 upward, and the undecoded offset 0x00.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int START_W    = 3;
  localparam int PSC_W      = 3;
  localparam int IE_BIT     = 3;
  localparam int FLAG_BIT   = 4;
  localparam int OFS_OUTCTL = 0;
  localparam int OFS_START  = 4;
  localparam int WIN_BASE   = 8;
  localparam int WIN_STRIDE = 12;
  localparam int CAPT_CH    = 2;

  typedef enum logic [1:0] {
    K_RELOAD = 2'd0,
    K_COUNT  = 2'd1,
    K_CTRL   = 2'd2,
    K_CAPT   = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [PSC_W-1:0] psc;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned NUM_DIV = 5
) (
  input  logic               clk,
  input  logic               rst,
  output logic [NUM_DIV-1:0] tick
);
  localparam int unsigned PRE_W = 2 * NUM_DIV;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    assign tick[k] = &pre_q[2*k+1:0];
    if (k > 0) begin : g_nest
      // R5: a slower tick always coincides with every faster one
      a_r5_tick_nested: assert property (@(posedge clk) disable iff (rst)
        tick[k] |-> tick[k-1]);
    end
  end
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned NCH        = 3,
  parameter bit          HAS_OUTCTL = 1'b1,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_outctl,
  output logic              hit_start,
  output logic [NCH-1:0]    ch_hit,
  output reg_kind_e         kind,
  output logic              hit_any
);
  always_comb begin
    int a;
    int base;
    int span;
    int off;
    a          = int'(addr);
    hit_outctl = HAS_OUTCTL && (a == OFS_OUTCTL);
    hit_start  = (a == OFS_START);
    ch_hit     = '0;
    kind       = K_RELOAD;
    for (int i = 0; i < int'(NCH); i++) begin
      base = WIN_BASE + WIN_STRIDE * i;
      span = (i == CAPT_CH) ? WIN_STRIDE + 4 : WIN_STRIDE;
      off  = a - base;
      if (off >= 0 && off < span && off[1:0] == 2'b00) begin
        ch_hit[i] = 1'b1;
        kind      = reg_kind_e'(off[3:2]);
      end
    end
    hit_any = hit_outctl | hit_start | (|ch_hit);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned         CNT_W     = 32,
  parameter int unsigned         DATA_W    = 32,
  parameter int unsigned         NUM_DIV   = 5,
  parameter bit                  HAS_CAPT  = 1'b0,
  parameter logic [DATA_W-1:0]   CAPT_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [NUM_DIV-1:0] tick,
  input  logic               wr_en,
  input  reg_kind_e          kind,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  localparam int unsigned SEL_MAX = NUM_DIV - 1;

  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  count_q;
  ctrl_t             ctrl_q;
  logic              irq_q;
  logic [DATA_W-1:0] capt;
  logic              step;
  logic              cnt_wr;
  logic              ctl_wr;
  logic              rld_wr;
  logic              advance;
  logic              wrap;

  always_comb begin
    if (int'(ctrl_q.psc) > int'(SEL_MAX)) step = tick[SEL_MAX];
    else                                  step = tick[ctrl_q.psc];
    cnt_wr  = wr_en && (kind == K_COUNT);
    ctl_wr  = wr_en && (kind == K_CTRL);
    rld_wr  = wr_en && (kind == K_RELOAD);
    advance = run && step && !cnt_wr;
    wrap    = advance && (count_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      ctrl_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (rld_wr) reload_q <= wdata[CNT_W-1:0];
      if (cnt_wr)       count_q <= wdata[CNT_W-1:0];
      else if (advance) count_q <= wrap ? reload_q : count_q - 1'b1;
      if (ctl_wr) begin
        ctrl_q.psc  <= wdata[PSC_W-1:0];
        ctrl_q.ie   <= wdata[IE_BIT];
        ctrl_q.flag <= (ctrl_q.flag & wdata[FLAG_BIT]) | wrap;
      end else begin
        ctrl_q.flag <= ctrl_q.flag | wrap;
      end
      irq_q <= ctrl_q.flag & ctrl_q.ie;
    end
  end

  if (HAS_CAPT) begin : g_capt
    logic [DATA_W-1:0] capt_q;
    always_ff @(posedge clk) begin
      if (rst)                         capt_q <= CAPT_INIT;
      else if (wr_en && kind == K_CAPT) capt_q <= wdata;
    end
    assign capt = capt_q;
  end else begin : g_nocapt
    assign capt = '0;
  end

  always_comb begin
    case (kind)
      K_RELOAD: rdata = DATA_W'(reload_q);
      K_COUNT:  rdata = DATA_W'(count_q);
      K_CTRL:   rdata = DATA_W'(ctrl_q);
      default:  rdata = capt;
    endcase
  end

  assign irq = irq_q;

  // R6: a stopped channel without a counter write keeps its count
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count_q));
  // R4: counting past zero loads the reload constant
  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    (advance && count_q == '0) |=> (count_q == $past(reload_q)));
  // R7: the flag is only cleared through a control write
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.flag && !ctl_wr) |=> ctrl_q.flag);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned       CNT_W      = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       ADDR_W     = 8,
  parameter bit                HAS_CH2    = 1'b1,
  parameter bit                HAS_OUTCTL = 1'b1,
  parameter int unsigned       NUM_DIV    = 5,
  parameter logic [DATA_W-1:0] CAPT_INIT  = 32'h0000_A5A5,
  localparam int unsigned      NCH        = HAS_CH2 ? 3 : 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [NCH-1:0]    irq,
  output logic              out_ctl
);
  logic               wr_stb;
  logic               rd_stb;
  logic               hit_outctl;
  logic               hit_start;
  logic [NCH-1:0]     ch_hit;
  reg_kind_e          kind;
  logic               hit_any;
  logic [NUM_DIV-1:0] tick;
  logic [START_W-1:0] start_q;
  logic [START_W-1:0] start_w;
  logic               outctl_q;
  logic               err_q;
  logic               bad_start;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  ch_rdata [NCH];
  logic [NCH-1:0]     ch_irq;

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  tmr_decode #(
    .NCH(NCH), .HAS_OUTCTL(HAS_OUTCTL), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr), .hit_outctl(hit_outctl), .hit_start(hit_start),
    .ch_hit(ch_hit), .kind(kind), .hit_any(hit_any)
  );

  tmr_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_DIV(NUM_DIV),
      .HAS_CAPT(i == CAPT_CH), .CAPT_INIT(CAPT_INIT)
    ) u_ch (
      .clk(clk), .rst(rst), .run(start_q[i]), .tick(tick),
      .wr_en(wr_stb && ch_hit[i]), .kind(kind), .wdata(bus_wdata),
      .rdata(ch_rdata[i]), .irq(ch_irq[i])
    );
  end

  always_comb begin
    start_w = bus_wdata[START_W-1:0];
    if (!HAS_CH2) start_w[CAPT_CH] = 1'b0;
    bad_start = wr_stb && hit_start && !HAS_CH2 && bus_wdata[CAPT_CH];
    rd_mux = '0;
    if (hit_outctl) rd_mux = DATA_W'(outctl_q);
    if (hit_start)  rd_mux = DATA_W'(start_q);
    for (int i = 0; i < int'(NCH); i++)
      if (ch_hit[i]) rd_mux = ch_rdata[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      outctl_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_stb && hit_start)  start_q  <= start_w;
      if (wr_stb && hit_outctl) outctl_q <= bus_wdata[0];
      if (rd_stb)               rdata_q  <= rd_mux;
      err_q <= err_q | (rd_stb && !hit_any) | bad_start;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign irq       = ch_irq;
  assign out_ctl   = outctl_q;

  // R2: an address selects at most one register target
  a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_outctl, hit_start, ch_hit}));
  // R10: the bus-error flag never clears outside reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> bus_err);
  // R12: read data holds when no read is made
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
  // R9: the output-control bit moves only on a write to it
  a_r9_outctl_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && hit_outctl) |=> $stable(out_ctl));
endmodule

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_next = 1'b1;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0;
  logic        err0, oc0;
  logic [2:0]  irq0;
  logic sel1 = 1'b0, wr1 = 1'b0;
  logic [7:0]  addr1 = '0;
  logic [31:0] wdata1 = '0;
  logic [31:0] rdata1;
  logic        err1, oc1;
  logic [1:0]  irq1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .bus_err(err0), .irq(irq0),
    .out_ctl(oc0)
  );

  tmr_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_sel(sel1), .bus_wr(wr1), .bus_addr(addr1),
    .bus_wdata(wdata1), .bus_rdata(rdata1), .bus_err(err1), .irq(irq1),
    .out_ctl(oc1)
  );

  // reference model state
  logic [31:0] m_reload [3];
  logic [31:0] m_count  [3];
  logic [2:0]  m_psc    [3];
  logic        m_ie     [3];
  logic        m_flag   [3];
  logic        m_irq    [3];
  logic [31:0] m_capt, m_rdata;
  logic [2:0]  m_start;
  logic        m_oc, m_err;
  int          m_pre;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_reload[i] = '1; m_count[i] = '1; m_psc[i] = '0;
      m_ie[i] = 1'b0; m_flag[i] = 1'b0; m_irq[i] = 1'b0;
    end
    m_capt = 32'h0000_A5A5; m_rdata = '0; m_start = '0;
    m_oc = 1'b0; m_err = 1'b0; m_pre = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a, output bit ok);
    ok = 1'b1;
    case (a)
      8'h00: m_read = {31'b0, m_oc};
      8'h04: m_read = {29'b0, m_start};
      8'h08: m_read = m_reload[0];
      8'h0C: m_read = m_count[0];
      8'h10: m_read = {27'b0, m_flag[0], m_ie[0], m_psc[0]};
      8'h14: m_read = m_reload[1];
      8'h18: m_read = m_count[1];
      8'h1C: m_read = {27'b0, m_flag[1], m_ie[1], m_psc[1]};
      8'h20: m_read = m_reload[2];
      8'h24: m_read = m_count[2];
      8'h28: m_read = {27'b0, m_flag[2], m_ie[2], m_psc[2]};
      8'h2C: m_read = m_capt;
      default: begin m_read = '0; ok = 1'b0; end
    endcase
  endfunction

  task automatic model_step(input bit s, input bit w, input logic [7:0] a,
                            input logic [31:0] d);
    bit tk [5];
    bit ok;
    logic [31:0] rv;
    for (int k = 0; k < 5; k++) begin
      int div;
      div = 1 << (2 * k + 2);
      tk[k] = (m_pre % div) == div - 1;
    end
    rv = m_read(a, ok);
    for (int i = 0; i < 3; i++) begin
      bit cw, tw, rw, adv, wrp;
      int idx;
      cw = s && w && int'(a) == 12 + 12 * i;
      tw = s && w && int'(a) == 16 + 12 * i;
      rw = s && w && int'(a) == 8 + 12 * i;
      idx = (m_psc[i] > 3'd4) ? 4 : int'(m_psc[i]);
      adv = m_start[i] && tk[idx] && !cw;
      wrp = adv && m_count[i] == 0;
      m_irq[i] = m_flag[i] & m_ie[i];
      if (cw)       m_count[i] = d;
      else if (adv) m_count[i] = wrp ? m_reload[i] : m_count[i] - 1;
      if (tw) begin
        m_flag[i] = (m_flag[i] & d[4]) | wrp;
        m_ie[i] = d[3];
        m_psc[i] = d[2:0];
      end else begin
        m_flag[i] = m_flag[i] | wrp;
      end
      if (rw) m_reload[i] = d;
    end
    if (s && w && a == 8'h2C) m_capt = d;
    if (s && w && a == 8'h04) m_start = d[2:0];
    if (s && w && a == 8'h00) m_oc = d[0];
    if (s && !w) begin
      m_rdata = rv;
      if (!ok) m_err = 1'b1;
    end
    m_pre = (m_pre + 1) % 1024;
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata", rdata0, m_rdata);
    chk(tag, "err", {31'b0, err0}, {31'b0, m_err});
    chk(tag, "irq", {29'b0, irq0}, {29'b0, m_irq[2], m_irq[1], m_irq[0]});
    chk(tag, "out_ctl", {31'b0, oc0}, {31'b0, m_oc});
  endtask

  task automatic cyc(input string tag, input bit s, input bit w,
                     input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    compare(tag);
    rst = rst_next; sel = s; wr = w; addr = a; wdata = d;
    if (rst_next) model_reset();
    else model_step(s, w, a, d);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, 1'b1, 1'b0, a, '0);
  endtask
  task automatic wrt(input string tag, input logic [7:0] a, input logic [31:0] d);
    cyc(tag, 1'b1, 1'b1, a, d);
  endtask
  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 8'h00, '0);
  endtask

  task automatic u1_acc(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel1 = 1'b1; wr1 = w; addr1 = a; wdata1 = d;
    @(negedge clk);
    sel1 = 1'b0; wr1 = 1'b0;
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rlist [6];
    rlist[0] = 8'h0C; rlist[1] = 8'h18; rlist[2] = 8'h24;
    rlist[3] = 8'h10; rlist[4] = 8'h1C; rlist[5] = 8'h28;
    model_reset();
    idle("R1", 4);
    rst_next = 1'b0;
    idle("R1", 2);
    // R1: reset values through reads
    for (int a = 0; a <= 'h2C; a += 4) rd("R1", 8'(a));
    rd("R1", 8'h0C); idle("R1", 1);
    chk("R1", "count0 reset", rdata0, 32'hFFFF_FFFF);
    rd("R1", 8'h2C); idle("R1", 1);
    chk("R1", "capture reset", rdata0, 32'h0000_A5A5);
    // R2: program all windows and read back
    wrt("R2", 8'h08, 32'h10); wrt("R2", 8'h0C, 32'h7); wrt("R2", 8'h10, 32'h08);
    wrt("R2", 8'h14, 32'h3);  wrt("R2", 8'h18, 32'h2); wrt("R2", 8'h1C, 32'h09);
    wrt("R2", 8'h20, 32'h1);  wrt("R2", 8'h24, 32'h0); wrt("R2", 8'h28, 32'h0F);
    wrt("R2", 8'h2C, 32'h1234_5678);
    for (int a = 8; a <= 'h2C; a += 4) rd("R2", 8'(a));
    rd("R2", 8'h2C); idle("R2", 1);
    chk("R2", "capture readback", rdata0, 32'h1234_5678);
    // R12: read data holds across idle cycles
    rd("R12", 8'h08); idle("R12", 5);
    chk("R12", "rdata held", rdata0, 32'h10);
    // R3: only low bits stored; channel 0 starts
    wrt("R3", 8'h04, 32'hF1); rd("R3", 8'h04); idle("R3", 1);
    chk("R3", "run readback", rdata0, 32'h1);
    for (int i = 0; i < 60; i++) rd("R4", (i % 2 == 0) ? 8'h0C : 8'h10);
    // R4 R5: all channels at different prescales
    wrt("R5", 8'h04, 32'h7);
    for (int i = 0; i < 2300; i++) rd("R5", rlist[i % 6]);
    // R7: clear and keep flags
    wrt("R7", 8'h10, 32'h08); idle("R7", 3);
    wrt("R7", 8'h1C, 32'h11); idle("R7", 3);
    wrt("R7", 8'h1C, 32'h01); idle("R7", 3);
    for (int i = 0; i < 80; i++) rd("R7", rlist[i % 6]);
    // R6: freeze channel 0 and resume
    wrt("R6", 8'h04, 32'h6);
    for (int i = 0; i < 40; i++) rd("R6", 8'h0C);
    wrt("R6", 8'h04, 32'h7);
    for (int i = 0; i < 30; i++) rd("R6", 8'h0C);
    // R8: counter write while running
    wrt("R8", 8'h0C, 32'h2);
    for (int i = 0; i < 20; i++) rd("R8", 8'h0C);
    // R9: output-control keeps bit 0
    wrt("R9", 8'h00, 32'hFFFF_FFFE); idle("R9", 1);
    wrt("R9", 8'h00, 32'h3); rd("R9", 8'h00); idle("R9", 1);
    chk("R9", "outctl readback", rdata0, 32'h1);
    // R10: undecoded write ignored, undecoded reads flag error
    wrt("R10", 8'h30, 32'hDEAD); wrt("R10", 8'h0E, 32'h55);
    for (int a = 0; a <= 'h2C; a += 4) rd("R10", 8'(a));
    chk("R10", "no error yet", {31'b0, err0}, 32'h0);
    rd("R10", 8'h30); idle("R10", 1);
    chk("R10", "undecoded read data", rdata0, 32'h0);
    chk("R10", "error set", {31'b0, err0}, 32'h1);
    rd("R10", 8'h02); rd("R10", 8'h44); idle("R10", 4);
    wrt("R10", 8'h0C, 32'h0); idle("R10", 1);
    // second build: no channel 2, no output control
    @(negedge clk);
    chk("R1", "u1 err after reset", {31'b0, err1}, 32'h0);
    u1_acc(1'b0, 8'h04, '0);
    chk("R1", "u1 run reset", rdata1, 32'h0);
    u1_acc(1'b1, 8'h14, 32'h55); u1_acc(1'b0, 8'h14, '0);
    chk("R2", "u1 ch1 reload", rdata1, 32'h55);
    chk("R11", "u1 no error before bad run", {31'b0, err1}, 32'h0);
    u1_acc(1'b1, 8'h04, 32'h7);
    chk("R11", "u1 bad run bit error", {31'b0, err1}, 32'h1);
    u1_acc(1'b0, 8'h04, '0);
    chk("R11", "u1 run bit2 dropped", rdata1, 32'h3);
    u1_acc(1'b1, 8'h20, 32'h5); u1_acc(1'b0, 8'h20, '0);
    chk("R11", "u1 window 0x20 reads 0", rdata1, 32'h0);
    u1_acc(1'b0, 8'h2C, '0);
    chk("R11", "u1 capture absent", rdata1, 32'h0);
    u1_acc(1'b1, 8'h00, 32'h1);
    chk("R9", "u1 out_ctl stays 0", {31'b0, oc1}, 32'h0);
    u1_acc(1'b0, 8'h00, '0);
    chk("R9", "u1 offset 0 reads 0", rdata1, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule